// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block sequences the control store of a horizontally microcoded processor. It holds the micro-program counter (the address of the current micro-instruction) and the micro-instruction register. It also holds a 512-word, 36-bit control store whose contents are computed when the design is built. In each machine cycle it forms the address of the following micro-instruction. It uses three inputs for this: the current word's next-address field, two ALU condition flags (negative and zero) latched inside the block, and the opcode byte from the instruction-byte register. The datapath receives the current word's 24 control bits unchanged.

The next address is not formed by an adder or a multiplexer tree. The low eight bits are the next-address field, with the opcode byte OR-ed in when the word asks for an opcode dispatch. The top bit is the field's top bit OR-ed with each flag whose jump-enable bit is set. Dispatch therefore only works if every opcode equals the control-store address of its micro-routine. A dispatching word normally carries 0x000 or 0x100 in its next-address field.

A machine cycle begins on the falling clock edge. On that edge the micro-instruction register loads the word the new address selects. The flag flip-flops load on the rising edge in the middle of the cycle, together with the datapath registers. The following address is computed from these freshly latched flags.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high at a rising edge, both flags read 0 after that edge. While `rst` is high at a falling edge, `uaddr` and `dp_ctrl` read 0 after that edge. On the first falling edge after `rst` falls, the word at address 0 is loaded.
- R2: Store word at address a (9 bits, with class c = a mod 4) holds these values. For c=0: next field a+1 (mod 512) and jump bits 000. For c=1: next field (a+2) mod 256 with only the negative-jump bit set. For c=2: next field (a+1) mod 256 with only the zero-jump bit set. For c=3: next field 0x000 when a<256 and 0x100 otherwise, with only the opcode-jump bit set. The control bits are {a, bitwise NOT a, a mod 64}.
- R3: Word layout, most significant bit first: next field in [35:27], opcode-jump in [26], negative-jump in [25], zero-jump in [24], control bits in [23:0]. When all three jump bits are 0, the next address equals the next field.
- R4: Next-address bit 8 is set when the next field's bit 8 is 1, or when the negative-jump bit and the latched N flag are both 1. It is cleared otherwise, unless R5 sets it.
- R5: When the zero-jump bit and the latched Z flag are both 1, next-address bit 8 is forced to 1.
- R6: When the opcode-jump bit is 1, next-address bits [7:0] equal next-field bits [7:0] OR `opcode`.
- R7: `n_flag` and `z_flag` take `alu_n` and `alu_z` at each rising edge. The next address uses the flag values latched at the rising edge inside the current cycle, and ignores later changes on `alu_n` and `alu_z`.
- R8: When the opcode-jump bit is 0, `opcode` has no effect on the next address.
- R9: After each falling edge, `uaddr` shows the address of the loaded word and `dp_ctrl` shows that word's control bits [23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; falling edge starts a machine cycle, rising edge latches flags |
| rst | input | 1 | Synchronous active-high reset |
| alu_n | input | 1 | ALU negative result, latched on the rising edge |
| alu_z | input | 1 | ALU zero result, latched on the rising edge |
| opcode | input | 8 | Opcode byte from the instruction-byte register |
| uaddr | output | 9 | Micro-program counter: address of the current word |
| next_uaddr | output | 9 | Address that the next falling edge will load |
| dp_ctrl | output | 24 | Datapath control bits of the current word |
| n_flag | output | 1 | Latched negative flag |
| z_flag | output | 1 | Latched zero flag |

## Verification
On every cycle, the assertions check that the address loaded at each falling edge agrees with the previous word's jump bits. This covers plain fall-through, both flag-forced high bits and the opcode OR. They also check that the flags track the ALU inputs edge by edge and clear under reset. Only the bench scenarios can show that the store contents and control bits match the computed layout. The same holds for the effect of ALU inputs that change after the rising edge, for correct restart from word 0 after a mid-run reset, and for long address walks that reach both halves of the store through dispatch.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int ADDR_W   = 9;
  localparam int OP_W     = 8;
  localparam int CTRL_W   = 24;
  localparam int JBITS    = 3;
  localparam int WORD_W   = ADDR_W + JBITS + CTRL_W;
  localparam int DEPTH    = 1 << ADDR_W;

  // Bit positions inside a micro-word (sequencer decodes these)
  localparam int NXT_LSB  = CTRL_W + JBITS;
  localparam int JMPC_BIT = CTRL_W + 2;
  localparam int JAMN_BIT = CTRL_W + 1;
  localparam int JAMZ_BIT = CTRL_W;

  typedef struct packed {
    logic [ADDR_W-1:0] nxt;
    logic              jmpc;
    logic              jamn;
    logic              jamz;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  // High address bit: field bit OR enabled flag conditions
  function automatic logic hi_bit(input logic nf_top, input logic jamn,
                                  input logic jamz, input logic n,
                                  input logic z);
    return nf_top | (jamn & n) | (jamz & z);
  endfunction

  // Low address bits: field, with opcode OR-ed in on dispatch
  function automatic logic [ADDR_W-2:0] lo_bits(
      input logic [ADDR_W-2:0] nf_lo, input logic jmpc,
      input logic [OP_W-1:0] op);
    logic [ADDR_W-2:0] mask;
    mask = jmpc ? (ADDR_W-1)'(op) : '0;
    return nf_lo | mask;
  endfunction

  // Control-store contents computed per address
  function automatic logic [WORD_W-1:0] rom_word(input int unsigned a);
    uword_t            w;
    logic [ADDR_W-1:0] ad;
    logic [ADDR_W-1:0] inc1;
    logic [ADDR_W-1:0] inc2;
    ad   = ADDR_W'(a);
    inc1 = ad + ADDR_W'(1);
    inc2 = ad + ADDR_W'(2);
    w.ctrl = {ad, ~ad, ad[5:0]};
    w.jmpc = 1'b0;
    w.jamn = 1'b0;
    w.jamz = 1'b0;
    case (ad[1:0])
      2'd0: w.nxt = inc1;
      2'd1: begin
        w.nxt  = {1'b0, inc2[ADDR_W-2:0]};
        w.jamn = 1'b1;
      end
      2'd2: begin
        w.nxt  = {1'b0, inc1[ADDR_W-2:0]};
        w.jamz = 1'b1;
      end
      default: begin
        w.nxt  = {ad[ADDR_W-1], {(ADDR_W-1){1'b0}}};
        w.jmpc = 1'b1;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
  parameter int ADDR_W = mseq_pkg::ADDR_W,
  parameter int WORD_W = mseq_pkg::WORD_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign mem[g] = WORD_W'(mseq_pkg::rom_word(g));
  end

  assign word = mem[addr];
endmodule

// File: rtl/mseq_flags.sv
module mseq_flags (
  input  logic clk,
  input  logic rst,
  input  logic alu_n,
  input  logic alu_z,
  output logic n_q,
  output logic z_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      n_q <= alu_n;
      z_q <= alu_z;
    end
  end
endmodule

// File: rtl/mseq_nextaddr.sv
module mseq_nextaddr #(
  parameter int ADDR_W = mseq_pkg::ADDR_W,
  parameter int OP_W   = mseq_pkg::OP_W
) (
  input  logic [ADDR_W-1:0] nf,
  input  logic              jmpc,
  input  logic              jamn,
  input  logic              jamz,
  input  logic              n,
  input  logic              z,
  input  logic [OP_W-1:0]   op,
  output logic [ADDR_W-1:0] nxt
);
  logic              hi;
  logic [ADDR_W-2:0] lo;

  always_comb begin
    hi  = mseq_pkg::hi_bit(nf[ADDR_W-1], jamn, jamz, n, z);
    lo  = mseq_pkg::lo_bits(nf[ADDR_W-2:0], jmpc, op);
    nxt = {hi, lo};
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top #(
  parameter int ADDR_W = mseq_pkg::ADDR_W,
  parameter int OP_W   = mseq_pkg::OP_W,
  parameter int CTRL_W = mseq_pkg::CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] uaddr,
  output logic [ADDR_W-1:0] next_uaddr,
  output logic [CTRL_W-1:0] dp_ctrl,
  output logic              n_flag,
  output logic              z_flag
);
  localparam int WORD_W  = ADDR_W + 3 + CTRL_W;
  localparam int NXT_LSB = CTRL_W + 3;

  logic [WORD_W-1:0] mir_q;
  logic [ADDR_W-1:0] mpc_q;
  logic [WORD_W-1:0] rom_out;
  logic [ADDR_W-1:0] nxt_addr;

  // Decoded fields of the current word, named for the checker
  logic [ADDR_W-1:0] cur_next;
  logic              cur_jmpc;
  logic              cur_jamn;
  logic              cur_jamz;

  assign cur_next = mir_q[WORD_W-1:NXT_LSB];
  assign cur_jmpc = mir_q[CTRL_W+2];
  assign cur_jamn = mir_q[CTRL_W+1];
  assign cur_jamz = mir_q[CTRL_W];

  mseq_flags u_flags (
    .clk  (clk),
    .rst  (rst),
    .alu_n(alu_n),
    .alu_z(alu_z),
    .n_q  (n_flag),
    .z_q  (z_flag)
  );

  mseq_nextaddr #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_next (
    .nf  (cur_next),
    .jmpc(cur_jmpc),
    .jamn(cur_jamn),
    .jamz(cur_jamz),
    .n   (n_flag),
    .z   (z_flag),
    .op  (opcode),
    .nxt (nxt_addr)
  );

  mseq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .addr(nxt_addr),
    .word(rom_out)
  );

  // Machine cycle starts on the falling edge
  always_ff @(negedge clk) begin
    if (rst) begin
      mpc_q <= '0;
      mir_q <= '0;
    end else begin
      mpc_q <= nxt_addr;
      mir_q <= rom_out;
    end
  end

  assign uaddr      = mpc_q;
  assign next_uaddr = nxt_addr;
  assign dp_ctrl    = mir_q[CTRL_W-1:0];
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int ADDR_W = mseq_pkg::ADDR_W,
  parameter int OP_W   = mseq_pkg::OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              alu_n,
  input logic              alu_z,
  input logic [OP_W-1:0]   opcode,
  input logic [ADDR_W-1:0] uaddr,
  input logic [ADDR_W-1:0] cur_next,
  input logic              cur_jmpc,
  input logic              cur_jamn,
  input logic              cur_jamz,
  input logic              n_flag,
  input logic              z_flag
);
  // R3
  seq_follow_chk: assert property (@(negedge clk) disable iff (rst)
    (!cur_jmpc && !cur_jamn && !cur_jamz) |=> uaddr == $past(cur_next));

  // R4
  n_branch_chk: assert property (@(negedge clk) disable iff (rst)
    (cur_jamn && n_flag) |=> uaddr[ADDR_W-1]);

  // R5
  z_branch_chk: assert property (@(negedge clk) disable iff (rst)
    (cur_jamz && z_flag) |=> uaddr[ADDR_W-1]);

  // R4
  hi_clear_chk: assert property (@(negedge clk) disable iff (rst)
    (!cur_next[ADDR_W-1] && !(cur_jamn && n_flag) && !(cur_jamz && z_flag))
      |=> !uaddr[ADDR_W-1]);

  // R6
  dispatch_low_chk: assert property (@(negedge clk) disable iff (rst)
    cur_jmpc |=> uaddr[ADDR_W-2:0] ==
      ($past(cur_next[ADDR_W-2:0]) | (ADDR_W-1)'($past(opcode))));

  // R8
  op_ignored_chk: assert property (@(negedge clk) disable iff (rst)
    !cur_jmpc |=> uaddr[ADDR_W-2:0] == $past(cur_next[ADDR_W-2:0]));

  // R7
  flag_latch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (n_flag == $past(alu_n)) && (z_flag == $past(alu_z)));

  // R1
  flag_reset_chk: assert property (@(posedge clk)
    rst |=> (!n_flag && !z_flag));
endmodule

bind mseq_top mseq_chk #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .alu_n   (alu_n),
  .alu_z   (alu_z),
  .opcode  (opcode),
  .uaddr   (uaddr),
  .cur_next(cur_next),
  .cur_jmpc(cur_jmpc),
  .cur_jamn(cur_jamn),
  .cur_jamz(cur_jamz),
  .n_flag  (n_flag),
  .z_flag  (z_flag)
);

// File: tb/mseq_top_tb.sv
`timescale 1ns/1ps
module mseq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alu_n = 1'b0;
  logic       alu_z = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [8:0] uaddr;
  logic [8:0] next_uaddr;
  logic [23:0] dp_ctrl;
  logic       n_flag;
  logic       z_flag;

  int checks = 0;
  int failures = 0;
  int cls_hits [4];
  int n_taken = 0, n_not = 0, z_taken = 0, hi_disp = 0;

  always #2.5 clk = ~clk;

  mseq_top u_dut (
    .clk(clk), .rst(rst), .alu_n(alu_n), .alu_z(alu_z), .opcode(opcode),
    .uaddr(uaddr), .next_uaddr(next_uaddr), .dp_ctrl(dp_ctrl),
    .n_flag(n_flag), .z_flag(z_flag)
  );

  // Bench view of the store contents, per R2
  function automatic int ref_next_field(int a);
    int c = a % 4;
    if (c == 0) return (a + 1) % 512;
    if (c == 1) return (a + 2) % 256;
    if (c == 2) return (a + 1) % 256;
    return (a >= 256) ? 256 : 0;
  endfunction

  function automatic logic [23:0] ref_ctrl(int a);
    return (24'(a) << 15) | (24'(511 - a) << 6) | 24'(a % 64);
  endfunction

  // Bench view of next-address formation, R3 to R6 and R8
  function automatic int ref_next_addr(int a, bit n, bit z, int op);
    int c = a % 4;
    int f = ref_next_field(a);
    int lo = f % 256;
    int hi = f / 256;
    if (c == 1 && n) hi = 1;
    if (c == 2 && z) hi = 1;
    if (c == 3) lo = lo | op;
    return hi * 256 + lo;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(int cycles, ref int addr);
    for (int i = 0; i < cycles; i++) begin
      bit n = 1'($urandom_range(0, 1));
      bit z = 1'($urandom_range(0, 1));
      int op = $urandom_range(0, 255);
      int c = addr % 4;
      int nxt;
      string tag;
      alu_n = n; alu_z = z; opcode = 8'(op);
      @(posedge clk); #1;
      check("R7 n_flag", n_flag, n);
      check("R7 z_flag", z_flag, z);
      // late change after the latch must not matter (R7)
      alu_n = ~n; alu_z = ~z;
      nxt = ref_next_addr(addr, n, z, op);
      if (c == 0) tag = "R3 fall-through/R8";
      else if (c == 1) tag = n ? "R4 N taken" : "R4 N untaken/R8";
      else if (c == 2) tag = z ? "R5 Z taken" : "R5 Z untaken/R8";
      else tag = "R6 dispatch";
      cls_hits[c]++;
      if (c == 1 && n) n_taken++;
      if (c == 1 && !n) n_not++;
      if (c == 2 && z) z_taken++;
      if (c == 3 && addr >= 256) hi_disp++;
      @(negedge clk); #1;
      check(tag, uaddr, nxt);
      check("R9 dp_ctrl", dp_ctrl, ref_ctrl(nxt));
      addr = nxt;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int addr;
    void'($urandom(32'h5EED));
    alu_n = 1'b1; alu_z = 1'b1; opcode = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset uaddr", uaddr, 0);
    check("R1 reset dp_ctrl", dp_ctrl, 0);
    check("R1 reset n_flag", n_flag, 0);
    check("R1 reset z_flag", z_flag, 0);
    rst = 1'b0;
    alu_n = 1'b0; alu_z = 1'b0;
    @(negedge clk); #1;
    check("R1 first word addr", uaddr, 0);
    check("R1 first word ctrl", dp_ctrl, ref_ctrl(0));
    addr = 0;

    // Directed: word 0 falls through to 1, word 1 branches on N
    run_walk(1, addr);
    check("R3 directed 0->1", addr, 1);
    alu_n = 1'b1;
    @(posedge clk); #1;
    alu_n = 1'b0; alu_z = 1'b1;
    @(negedge clk); #1;
    check("R4 directed N taken", uaddr, 259);
    check("R2 ctrl of 259", dp_ctrl, ref_ctrl(259));
    addr = 259;
    // 259 dispatches from the upper half
    opcode = 8'h06; alu_n = 1'b0; alu_z = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); #1;
    check("R6 directed dispatch 0x100|0x06", uaddr, 262);
    addr = 262;
    // 262 is a Z-branch word: Z taken keeps bit 8, field is 7
    alu_z = 1'b1; opcode = 8'hF0;
    @(posedge clk); #1;
    alu_z = 1'b0;
    @(negedge clk); #1;
    check("R5 directed Z taken", uaddr, 263);
    addr = 263;

    run_walk(3000, addr);

    // Mid-run reset
    rst = 1'b1; alu_n = 1'b1; alu_z = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset n_flag", n_flag, 0);
    check("R1 mid reset z_flag", z_flag, 0);
    @(negedge clk); #1;
    check("R1 mid reset uaddr", uaddr, 0);
    check("R1 mid reset dp_ctrl", dp_ctrl, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 restart word 0", uaddr, 0);
    addr = 0;
    run_walk(1000, addr);

    check("R3 coverage", int'(cls_hits[0] > 0), 1);
    check("R4 coverage taken", int'(n_taken > 0), 1);
    check("R4 coverage untaken", int'(n_not > 0), 1);
    check("R5 coverage taken", int'(z_taken > 0), 1);
    check("R6 coverage upper dispatch", int'(hi_disp > 0), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule